// File: doc/BRIEF.md
# UART FIFO Ready Pin Generator

This block produces the two active-low ready strobes of a 16C550-style UART: one tells a bus-side mover that received data can be read, the other that transmit data can be written. It holds a small receive FIFO and a small transmit FIFO, each with push and pop ports. The ready strobes are derived from the FIFO fill levels, the FIFO enable control and the block-transfer control. A programmable receive trigger level and a receive character time-out flag are also inputs.

Three modes come from the two control inputs. With FIFOs off, each side behaves as a single holding register. With FIFOs on and block transfer off, the ready strobes report per-character availability. With block transfer on, the receive strobe has hysteresis and the transmit strobe reports free space instead of emptiness. Every strobe is registered, so it moves one clock after the fill count that drives it.

Top module: `uart_rdy_gen`

## Requirements
- R1: While rst_ni is low, rx_rdy_no and tx_rdy_no are 1, rx_cnt_o and tx_cnt_o are 0 and rx_ovf_o is 0.
- R2: With fifo_en_i=0 each FIFO holds at most one byte. rx_rdy_no is 0 when that byte is held and 1 when none is held. tx_rdy_no is 0 when the transmit side is empty and 1 when it holds a byte.
- R3: With fifo_en_i=1 and blk_mode_i=0, rx_rdy_no is 0 exactly when rx_cnt_o is at least 1. Every ready output takes its new value one clock after the count change that causes it.
- R4: With fifo_en_i=1 and blk_mode_i=0, tx_rdy_no is 0 only when tx_cnt_o is 0, and 1 while any byte is held.
- R5: With fifo_en_i=1 and blk_mode_i=1, rx_rdy_no goes to 0 once rx_cnt_o is at least rx_trig_i, or on a cycle with rx_timeout_i=1 and a non-empty FIFO. It then stays 0 until rx_cnt_o reaches 0.
- R6: With fifo_en_i=1 and blk_mode_i=1, tx_rdy_no is 0 while tx_cnt_o is below DEPTH and 1 when the FIFO is full.
- R7: A time-out while the receive FIFO is empty does not assert rx_rdy_no, because the empty condition wins.
- R8: Any change of the mode chosen by fifo_en_i and blk_mode_i clears the block-mode receive flag. One clock after such a change into block mode, rx_rdy_no is 1 until the trigger or a time-out occurs again.
- R9: A change of fifo_en_i empties both FIFOs; both counts are 0 at the next clock.
- R10: A push into a full FIFO leaves its count and contents unchanged. A pop from an empty FIFO leaves its count at 0. A push and a pop in the same cycle on a full FIFO perform only the pop.
- R11: A receive push that is dropped because the FIFO is full makes rx_ovf_o 1 for exactly the following clock cycle.
- R12: Each FIFO is first-in first-out, and the oldest byte is visible on its data output while the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO enable control |
| blk_mode_i | input | 1 | Block-transfer mode control |
| rx_trig_i | input | CW | Receive trigger level, 1 to DEPTH |
| rx_timeout_i | input | 1 | Receive character time-out flag |
| rx_push_i | input | 1 | Write a received byte |
| rx_data_i | input | WIDTH | Received byte |
| rx_pop_i | input | 1 | Read the oldest received byte |
| rx_data_o | output | WIDTH | Oldest received byte |
| rx_cnt_o | output | CW | Receive fill count |
| rx_ovf_o | output | 1 | One-cycle pulse after a dropped receive push |
| tx_push_i | input | 1 | Write a byte to transmit |
| tx_data_i | input | WIDTH | Byte to transmit |
| tx_pop_i | input | 1 | Take the oldest transmit byte |
| tx_data_o | output | WIDTH | Oldest transmit byte |
| tx_cnt_o | output | CW | Transmit fill count |
| rx_rdy_no | output | 1 | Receive ready, active low |
| tx_rdy_no | output | 1 | Transmit ready, active low |

## Verification
A block-mode flag left stuck set shows up as rx_rdy_no staying 0 one clock after the receive FIFO has drained. A flag not cleared on a mode change shows up as rx_rdy_no at 0 one clock after re-entering block mode with the count below the trigger level. A miscounted fill level shows up as a ready strobe moving one push or pop early or late, and as a missing or spurious rx_ovf_o pulse on the clock after the push that reaches the limit. A flush that does not happen on a FIFO enable change leaves a non-zero count visible at the very next clock.

// File: rtl/uart_rdy_pkg.sv
package uart_rdy_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_CHAR  = 2'd1,
    MODE_BLOCK = 2'd2
  } rdy_mode_e;

  function automatic rdy_mode_e decode_mode(input logic fifo_en, input logic blk);
    if (!fifo_en)  return MODE_HOLD;
    else if (blk)  return MODE_BLOCK;
    else           return MODE_CHAR;
  endfunction
endpackage

// File: rtl/rdy_fifo.sv
module rdy_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [CW-1:0]    lim_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    cnt_o,
  output logic             full_o,
  output logic             drop_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             push_ok, pop_ok, empty;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full_o  = (cnt_q >= lim_i);
  assign push_ok = push_i & ~full_o & ~flush_i;
  assign pop_ok  = pop_i & ~empty & ~flush_i;
  assign drop_o  = push_i & full_o & ~flush_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_ok && wr_ptr_q == AW'(i)) mem_q[i] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + CW'(1);
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign data_o = mem_q[rd_ptr_q];
  assign cnt_o  = cnt_q;

  // R10: dropped push changes nothing
  a_r10_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(cnt_o));
  // R10: pop of empty FIFO ignored
  a_r10_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i) |=> (cnt_o == '0));
  // R9: flush empties
  a_r9_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_o == '0));
  a_r10_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(DEPTH));
endmodule

// File: rtl/rdy_rx_ctl.sv
module rdy_rx_ctl
  import uart_rdy_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  rdy_mode_e     mode_i,
  input  logic          chg_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] trig_i,
  input  logic          timeout_i,
  output logic          rdy_no
);
  logic blk_q, blk_d, rdy_d, rdy_q;

  // empty and mode change win over trigger and time-out
  always_comb begin
    blk_d = blk_q;
    if (mode_i != MODE_BLOCK || chg_i || cnt_i == '0) blk_d = 1'b0;
    else if (cnt_i >= trig_i || timeout_i)            blk_d = 1'b1;
    rdy_d = (mode_i == MODE_BLOCK) ? ~blk_d : (cnt_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= 1'b0;
      rdy_q <= 1'b1;
    end else begin
      blk_q <= blk_d;
      rdy_q <= rdy_d;
    end
  end

  assign rdy_no = rdy_q;

  // R3, R7: empty FIFO always releases
  a_r7_empty_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> rdy_no);
  a_r3_char_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_BLOCK && cnt_i != '0) |=> !rdy_no);
  // R5: trigger or time-out asserts
  a_r5_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BLOCK && !chg_i && cnt_i != '0 && (cnt_i >= trig_i || timeout_i))
      |=> !rdy_no);
  // R5: hysteresis, held until empty
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BLOCK && !chg_i && !rdy_no && cnt_i != '0) |=> !rdy_no);
  // R8: mode change clears flag
  a_r8_mode_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i && mode_i == MODE_BLOCK) |=> rdy_no);
endmodule

// File: rtl/rdy_tx_ctl.sv
module rdy_tx_ctl
  import uart_rdy_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  rdy_mode_e     mode_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          full_i,
  output logic          rdy_no
);
  logic rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rdy_q <= 1'b1;
    else if (mode_i == MODE_BLOCK)  rdy_q <= full_i;
    else                            rdy_q <= (cnt_i != '0);
  end

  assign rdy_no = rdy_q;

  // R6: block mode reports free space
  a_r6_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BLOCK && full_i) |=> rdy_no);
  a_r6_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BLOCK && !full_i) |=> !rdy_no);
  // R4: character mode reports emptiness
  a_r4_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_BLOCK && cnt_i != '0) |=> rdy_no);
  a_r4_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_BLOCK && cnt_i == '0) |=> !rdy_no);
endmodule

// File: rtl/uart_rdy_gen.sv
module uart_rdy_gen
  import uart_rdy_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             blk_mode_i,
  input  logic [CW-1:0]    rx_trig_i,
  input  logic             rx_timeout_i,
  input  logic             rx_push_i,
  input  logic [WIDTH-1:0] rx_data_i,
  input  logic             rx_pop_i,
  output logic [WIDTH-1:0] rx_data_o,
  output logic [CW-1:0]    rx_cnt_o,
  output logic             rx_ovf_o,
  input  logic             tx_push_i,
  input  logic [WIDTH-1:0] tx_data_i,
  input  logic             tx_pop_i,
  output logic [WIDTH-1:0] tx_data_o,
  output logic [CW-1:0]    tx_cnt_o,
  output logic             rx_rdy_no,
  output logic             tx_rdy_no
);
  rdy_mode_e     mode_d, mode_q;
  logic          chg, flush, ovf_q;
  logic [CW-1:0] lim;
  logic          rx_full, rx_drop, tx_full, tx_drop;

  assign mode_d = decode_mode(fifo_en_i, blk_mode_i);
  assign chg    = (mode_d != mode_q);
  assign flush  = ((mode_d == MODE_HOLD) != (mode_q == MODE_HOLD));
  // FIFOs off: one-entry holding register
  assign lim    = (mode_d == MODE_HOLD) ? CW'(1) : CW'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_HOLD;
      ovf_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ovf_q  <= rx_drop;
    end
  end

  assign rx_ovf_o = ovf_q;

  rdy_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .lim_i(lim),
    .push_i(rx_push_i), .data_i(rx_data_i), .pop_i(rx_pop_i),
    .data_o(rx_data_o), .cnt_o(rx_cnt_o), .full_o(rx_full), .drop_o(rx_drop)
  );

  rdy_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .lim_i(lim),
    .push_i(tx_push_i), .data_i(tx_data_i), .pop_i(tx_pop_i),
    .data_o(tx_data_o), .cnt_o(tx_cnt_o), .full_o(tx_full), .drop_o(tx_drop)
  );

  rdy_rx_ctl #(.CW(CW)) u_rx_ctl (
    .clk_i, .rst_ni, .mode_i(mode_d), .chg_i(chg), .cnt_i(rx_cnt_o),
    .trig_i(rx_trig_i), .timeout_i(rx_timeout_i), .rdy_no(rx_rdy_no)
  );

  rdy_tx_ctl #(.CW(CW)) u_tx_ctl (
    .clk_i, .rst_ni, .mode_i(mode_d), .cnt_i(tx_cnt_o), .full_i(tx_full),
    .rdy_no(tx_rdy_no)
  );

  // R11: dropped receive push pulses overflow
  a_r11_ovf_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop |=> rx_ovf_o);
  a_r11_ovf_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_drop |=> !rx_ovf_o);
  // R2: FIFOs off hold one byte
  a_r2_hold_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_HOLD) |-> (rx_cnt_o <= CW'(1) && tx_cnt_o <= CW'(1)));
  a_r10_tx_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_drop && !tx_pop_i) |=> $stable(tx_cnt_o));
endmodule

// File: tb/uart_rdy_gen_tb_top.sv
`timescale 1ns/1ps
module uart_rdy_gen_tb_top;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 0, blk = 0, tmo = 0;
  logic [CW-1:0] trig = CW'(4);
  logic rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
  logic [7:0] rx_din = 0, tx_din = 0, rx_dout, tx_dout;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic rx_ovf, rx_rdy_n, tx_rdy_n;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_rdy_gen #(.DEPTH(DEPTH), .WIDTH(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .blk_mode_i(blk),
    .rx_trig_i(trig), .rx_timeout_i(tmo), .rx_push_i(rx_push), .rx_data_i(rx_din),
    .rx_pop_i(rx_pop), .rx_data_o(rx_dout), .rx_cnt_o(rx_cnt), .rx_ovf_o(rx_ovf),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop), .tx_data_o(tx_dout),
    .tx_cnt_o(tx_cnt), .rx_rdy_no(rx_rdy_n), .tx_rdy_no(tx_rdy_n)
  );

  task automatic chk(input int act, input int exp, input string what);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_push = 1; rx_din = d; step(); rx_push = 0;
  endtask
  task automatic pop_rx();
    rx_pop = 1; step(); rx_pop = 0;
  endtask
  task automatic push_tx(input logic [7:0] d);
    tx_push = 1; tx_din = d; step(); tx_push = 0;
  endtask
  task automatic pop_tx();
    tx_pop = 1; step(); tx_pop = 0;
  endtask

  task automatic t_reset();
    chk(rx_rdy_n, 1, "R1 rx_rdy in reset");
    chk(tx_rdy_n, 1, "R1 tx_rdy in reset");
    chk(rx_cnt, 0, "R1 rx_cnt in reset");
    chk(tx_cnt, 0, "R1 tx_cnt in reset");
    chk(rx_ovf, 0, "R1 ovf in reset");
  endtask

  task automatic t_hold();
    fifo_en = 0; blk = 0;
    push_rx(8'h11);
    chk(rx_cnt, 1, "R2 rx holds byte");
    chk(rx_rdy_n, 1, "R3 rx_rdy lags count by one clock");
    step();
    chk(rx_rdy_n, 0, "R2 rx_rdy low with byte");
    push_rx(8'h22);
    chk(rx_cnt, 1, "R2 rx one byte limit");
    chk(rx_ovf, 1, "R11 ovf after dropped push");
    chk(rx_dout, 8'h11, "R10 held byte kept");
    step();
    chk(rx_ovf, 0, "R11 ovf one cycle only");
    pop_rx(); step();
    chk(rx_rdy_n, 1, "R2 rx_rdy high when empty");
    push_tx(8'h33);
    chk(tx_rdy_n, 0, "R2 tx_rdy lags");
    step();
    chk(tx_rdy_n, 1, "R2 tx_rdy high with byte");
    push_tx(8'h44);
    chk(tx_cnt, 1, "R2 tx one byte limit");
    pop_tx(); step();
    chk(tx_rdy_n, 0, "R2 tx_rdy low when empty");
  endtask

  task automatic t_flush();
    fifo_en = 0;
    push_rx(8'h55); push_tx(8'h66);
    fifo_en = 1; step();
    chk(rx_cnt, 0, "R9 rx flushed on enable");
    chk(tx_cnt, 0, "R9 tx flushed on enable");
    step();
  endtask

  task automatic t_char();
    fifo_en = 1; blk = 0; step(2);
    push_rx(8'hA0); push_rx(8'hA1); push_rx(8'hA2); step();
    chk(rx_rdy_n, 0, "R3 rx_rdy low with data");
    chk(rx_cnt, 3, "R3 rx count");
    for (int i = 0; i < 3; i++) begin
      chk(rx_dout, 8'hA0 + i, "R12 rx order");
      pop_rx();
    end
    chk(rx_rdy_n, 0, "R3 rx_rdy still low before update");
    step();
    chk(rx_rdy_n, 1, "R3 rx_rdy high when empty");
    push_tx(8'hB0); step();
    chk(tx_rdy_n, 1, "R4 tx_rdy high with one byte");
    push_tx(8'hB1); push_tx(8'hB2);
    pop_tx(); pop_tx(); step();
    chk(tx_rdy_n, 1, "R4 tx_rdy high with one left");
    chk(tx_dout, 8'hB2, "R12 tx order");
    pop_tx(); step();
    chk(tx_rdy_n, 0, "R4 tx_rdy low when empty");
  endtask

  task automatic t_full();
    fifo_en = 1; blk = 0; step();
    for (int i = 0; i < DEPTH; i++) push_rx(8'(i));
    chk(rx_ovf, 0, "R11 no ovf on last fitting push");
    push_rx(8'hFF);
    chk(rx_cnt, DEPTH, "R10 push into full ignored");
    chk(rx_ovf, 1, "R11 ovf on full FIFO");
    rx_push = 1; rx_din = 8'hEE; rx_pop = 1; step(); rx_push = 0; rx_pop = 0;
    chk(rx_cnt, DEPTH - 1, "R10 push+pop on full pops only");
    for (int i = 1; i < DEPTH; i++) begin
      chk(rx_dout, i, "R12 rx order after overflow");
      pop_rx();
    end
    pop_rx();
    chk(rx_cnt, 0, "R10 pop of empty ignored");
    step();
  endtask

  task automatic t_block_rx();
    fifo_en = 1; blk = 1; trig = CW'(4); step(2);
    tmo = 1; step(); tmo = 0;
    chk(rx_rdy_n, 1, "R7 time-out on empty ignored");
    push_rx(1); push_rx(2); push_rx(3); step();
    chk(rx_rdy_n, 1, "R5 below trigger");
    push_rx(4); step();
    chk(rx_rdy_n, 0, "R5 at trigger");
    pop_rx(); pop_rx(); pop_rx(); step();
    chk(rx_rdy_n, 0, "R5 held below trigger");
    pop_rx(); step();
    chk(rx_rdy_n, 1, "R5 released at empty");
    push_rx(5); push_rx(6); step();
    chk(rx_rdy_n, 1, "R5 two bytes below trigger");
    tmo = 1; step(); tmo = 0;
    chk(rx_rdy_n, 0, "R5 time-out asserts");
  endtask

  task automatic t_mode_clear();
    blk = 0; step(); blk = 1; step(2);
    chk(rx_rdy_n, 1, "R8 flag cleared by mode change");
    chk(rx_cnt, 2, "R8 data kept across block toggle");
    pop_rx(); pop_rx(); step();
  endtask

  task automatic t_block_tx();
    fifo_en = 1; blk = 1; step(2);
    chk(tx_rdy_n, 0, "R6 tx_rdy low when empty");
    for (int i = 0; i < DEPTH - 1; i++) push_tx(8'(i));
    step();
    chk(tx_rdy_n, 0, "R6 tx_rdy low with one free slot");
    push_tx(8'hC0);
    chk(tx_cnt, DEPTH, "R6 tx full count");
    step();
    chk(tx_rdy_n, 1, "R6 tx_rdy high when full");
    push_tx(8'hC1);
    chk(tx_cnt, DEPTH, "R10 tx push into full ignored");
    pop_tx(); step();
    chk(tx_rdy_n, 0, "R6 tx_rdy low after one pop");
    for (int i = 0; i < DEPTH - 1; i++) pop_tx();
    chk(tx_cnt, 0, "R6 tx drained");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1; step();
    t_hold();
    t_flush();
    t_char();
    t_full();
    t_block_rx();
    t_mode_clear();
    t_block_tx();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
    end
  end
endmodule